// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block keeps the reservations that let software build atomic read-modify-write sequences out of two accesses: a load-linked that reads a word and reserves it, and a later store-conditional that writes the word only if nothing has disturbed it in between. It holds a small table of reserved word addresses. It watches every store that reaches the memory write port, whether it comes from this requester or another one, and drops any reservation for the word being written.

When a store-conditional arrives, the unit takes two inputs into account. The first is a predicate computed from a condition register, with three selectable tests. The second is whether a live reservation exists for the target word. The write may proceed only when both hold. One cycle later the unit drives a write-enable for the memory path and a status word for the destination register. The status is 1 on success and 0 on failure. A store-conditional always consumes the reservation for its word. A flush input, asserted on a context switch or interrupt entry, drops every reservation, so a reservation cannot outlive a change of software context.

The data storage, the memory and the instruction decode sit outside the block. It sees only addresses, the condition operand and the predicate selector.

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset no reservation is held, `sc_we_o` and `sc_status_valid_o` are low, and a store-conditional without a prior load-linked fails.
- R2: A load-linked to a word creates a reservation. A later store-conditional to that word whose predicate holds succeeds.
- R3: Reservations are kept per aligned 8-byte word. Address bits [2:0] are ignored. An access to a different word of the same line neither matches nor clears the reservation.
- R4: A snooped store to a reserved word clears that reservation. A snooped store to another word leaves it intact.
- R5: A store-conditional clears the reservation for its word whether it succeeds or fails, so a second store-conditional to that word fails.
- R6: `sc_pred_i` selects the predicate on `sc_cond_i`: 0 = operand equals zero, 1 = bit 0 set, 2 = most significant bit set, 3 = never true. A false predicate makes the store fail.
- R7: `sc_status_valid_o` is high for exactly one cycle, the cycle after each store-conditional request. `sc_status_o` is then 1 on success and 0 on failure. `sc_we_o` is high in that cycle only on success.
- R8: A flush pulse clears every reservation.
- R9: The table holds 4 reservations. A load-linked to an already reserved word reuses that entry. Otherwise it takes the lowest free entry. When the table is full it replaces entries in round-robin order, starting at entry 0 after reset.
- R10: A snooped store and a store-conditional to the same word in one cycle make the store-conditional fail. A load-linked in the same cycle as a store (snooped or conditional) to its word creates no reservation.
- R11: A flush in the same cycle as a store-conditional makes it fail, and a flush in the same cycle as a load-linked creates no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Context switch / interrupt entry: clear all reservations |
| ll_valid_i | input | 1 | Load-linked request |
| ll_addr_i | input | ADDR_W | Load-linked byte address |
| snoop_valid_i | input | 1 | A store is on the memory write port |
| snoop_addr_i | input | ADDR_W | Byte address of the snooped store |
| sc_valid_i | input | 1 | Store-conditional request |
| sc_addr_i | input | ADDR_W | Store-conditional byte address |
| sc_pred_i | input | 2 | Predicate select (0 zero, 1 LSB, 2 MSB, 3 never) |
| sc_cond_i | input | DATA_W | Condition register operand |
| sc_we_o | output | 1 | Memory write-enable for the store-conditional, one cycle after the request |
| sc_status_valid_o | output | 1 | Status word valid pulse |
| sc_status_o | output | DATA_W | Status for the destination register (1 success, 0 failure) |

## Verification
On every cycle the assertions check the timing and shape of the status pulse, that the write-enable appears only together with a success status, and that a flush empties the table on the next edge. They also check that a false predicate, a concurrent flush or a same-word snooped store always blocks the write. Whether a reservation actually survives unrelated traffic, which entry a full table replaces, and that word granularity separates neighbours in a line depend on earlier history. Only the bench scenarios show these, through chains of load-linked, store and store-conditional requests.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    PRED_ZERO  = 2'd0,
    PRED_LSB   = 2'd1,
    PRED_MSB   = 2'd2,
    PRED_NEVER = 2'd3
  } pred_sel_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/llsc_pred.sv
module llsc_pred #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] cond_i,
  output logic              pass_o
);
  import llsc_pkg::*;

  pred_sel_e sel;
  assign sel = pred_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      PRED_ZERO: pass_o = (cond_i == '0);
      PRED_LSB:  pass_o = cond_i[0];
      PRED_MSB:  pass_o = cond_i[DATA_W-1];
      default:   pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/llsc_tag_match.sv
module llsc_tag_match #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 29
) (
  input  logic                      en_i,
  input  logic [TAG_W-1:0]          probe_i,
  input  logic [N-1:0]              valid_i,
  input  logic [N-1:0][TAG_W-1:0]   tags_i,
  output logic [N-1:0]              hit_o
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = en_i && valid_i[i] && (tags_i[i] == probe_i);
  end

endmodule

// File: rtl/llsc_victim_sel.sv
module llsc_victim_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     hit_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             any_hit, any_free;

  // lowest index wins in both scans
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_hit  = |hit_i;
    any_free = ~&valid_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i])    hit_idx  = IDX_W'(i);
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (any_hit)       idx_o = hit_idx;
    else if (any_free) idx_o = free_idx;
    else               idx_o = rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && !any_hit && !any_free) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 29,
  parameter int unsigned IDX_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_all_i,
  input  logic [N-1:0]            kill_i,
  input  logic                    set_i,
  input  logic [IDX_W-1:0]        set_idx_i,
  input  logic [TAG_W-1:0]        set_tag_i,
  output logic [N-1:0]            valid_o,
  output logic [N-1:0][TAG_W-1:0] tags_o
);

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;
    logic             sel;

    assign sel = set_i && (set_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        tag_q <= '0;
      end else if (clr_all_i) begin
        vld_q <= 1'b0;
      end else if (sel) begin
        vld_q <= 1'b1;
        tag_q <= set_tag_i;
      end else if (kill_i[i]) begin
        vld_q <= 1'b0;
      end
    end

    assign valid_o[i] = vld_q;
    assign tags_o[i]  = tag_q;
  end

endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned N_ENTRIES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ll_valid_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [1:0]        sc_pred_i,
  input  logic [DATA_W-1:0] sc_cond_i,
  output logic              sc_we_o,
  output logic              sc_status_valid_o,
  output logic [DATA_W-1:0] sc_status_o
);
  import llsc_pkg::*;

  localparam int unsigned OFF_W = $clog2(WORD_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W = idx_width(N_ENTRIES);

  logic [TAG_W-1:0] ll_tag, sn_tag, sc_tag;
  assign ll_tag = ll_addr_i[ADDR_W-1:OFF_W];
  assign sn_tag = snoop_addr_i[ADDR_W-1:OFF_W];
  assign sc_tag = sc_addr_i[ADDR_W-1:OFF_W];

  logic unused_offsets;
  assign unused_offsets = ^{ll_addr_i[OFF_W-1:0], snoop_addr_i[OFF_W-1:0],
                            sc_addr_i[OFF_W-1:0]};

  logic [N_ENTRIES-1:0]            resv_valid;
  logic [N_ENTRIES-1:0][TAG_W-1:0] resv_tags;
  logic [N_ENTRIES-1:0]            ll_hit, sn_hit, sc_hit;

  llsc_tag_match #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_match_ll (
    .en_i(ll_valid_i), .probe_i(ll_tag), .valid_i(resv_valid),
    .tags_i(resv_tags), .hit_o(ll_hit)
  );

  llsc_tag_match #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_match_sn (
    .en_i(snoop_valid_i), .probe_i(sn_tag), .valid_i(resv_valid),
    .tags_i(resv_tags), .hit_o(sn_hit)
  );

  llsc_tag_match #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_match_sc (
    .en_i(sc_valid_i), .probe_i(sc_tag), .valid_i(resv_valid),
    .tags_i(resv_tags), .hit_o(sc_hit)
  );

  logic pred_pass;
  llsc_pred #(.DATA_W(DATA_W)) u_pred (
    .sel_i(sc_pred_i), .cond_i(sc_cond_i), .pass_o(pred_pass)
  );

  // same-cycle hazards: stores and flush dominate
  logic sn_sc_same, ll_blocked, ll_set, sc_ok;
  assign sn_sc_same = snoop_valid_i && sc_valid_i && (sn_tag == sc_tag);
  assign ll_blocked = flush_i
                   || (snoop_valid_i && (sn_tag == ll_tag))
                   || (sc_valid_i && (sc_tag == ll_tag));
  assign ll_set     = ll_valid_i && !ll_blocked;
  assign sc_ok      = sc_valid_i && pred_pass && (|sc_hit) && !flush_i && !sn_sc_same;

  logic [IDX_W-1:0] alloc_idx;
  llsc_victim_sel #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(resv_valid), .hit_i(ll_hit),
    .alloc_i(ll_set), .idx_o(alloc_idx)
  );

  llsc_resv_table #(.N(N_ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_all_i(flush_i),
    .kill_i(sn_hit | sc_hit), .set_i(ll_set), .set_idx_i(alloc_idx),
    .set_tag_i(ll_tag), .valid_o(resv_valid), .tags_o(resv_tags)
  );

  logic we_q, stat_v_q, stat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q     <= 1'b0;
      stat_v_q <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      we_q     <= sc_ok;
      stat_v_q <= sc_valid_i;
      stat_q   <= sc_ok;
    end
  end

  assign sc_we_o           = we_q;
  assign sc_status_valid_o = stat_v_q;
  assign sc_status_o       = {{(DATA_W-1){1'b0}}, stat_q};

endmodule

// File: rtl/llsc_resv_unit_sva.sv
module llsc_resv_unit_sva #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned N_ENTRIES  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flush_i,
  input logic                 snoop_valid_i,
  input logic [ADDR_W-1:0]    snoop_addr_i,
  input logic                 sc_valid_i,
  input logic [ADDR_W-1:0]    sc_addr_i,
  input logic [1:0]           sc_pred_i,
  input logic [DATA_W-1:0]    sc_cond_i,
  input logic                 sc_we_o,
  input logic                 sc_status_valid_o,
  input logic [DATA_W-1:0]    sc_status_o,
  input logic [N_ENTRIES-1:0] resv_valid_i
);
  localparam int unsigned OFF_W = $clog2(WORD_BYTES);

  logic same_word;
  assign same_word = snoop_addr_i[ADDR_W-1:OFF_W] == sc_addr_i[ADDR_W-1:OFF_W];

  logic armed;
  always_ff @(posedge clk_i) armed <= 1'b1;

  always @(negedge clk_i) begin
    if (armed === 1'b1 && !rst_ni) begin
      assert_reset_state_R1: assert (resv_valid_i == '0 && !sc_we_o && !sc_status_valid_o);
    end
  end

  assert_status_follows_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_valid_i |=> sc_status_valid_o);

  assert_no_spurious_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_valid_i |=> !sc_status_valid_o);

  assert_we_with_success_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_we_o |-> (sc_status_valid_o && sc_status_o == DATA_W'(1)));

  assert_status_binary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_status_valid_o |-> (sc_status_o[DATA_W-1:1] == '0 && sc_status_o[0] == sc_we_o));

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (resv_valid_i == '0));

  assert_flush_blocks_sc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && sc_valid_i) |=> !sc_we_o);

  assert_snoop_beats_sc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && snoop_valid_i && same_word) |=> !sc_we_o);

  assert_pred_zero_false_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && sc_pred_i == 2'd0 && sc_cond_i != '0) |=> !sc_we_o);

  assert_pred_never_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && sc_pred_i == 2'd3) |=> !sc_we_o);

endmodule

bind llsc_resv_unit llsc_resv_unit_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES), .N_ENTRIES(N_ENTRIES)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
  .sc_valid_i(sc_valid_i), .sc_addr_i(sc_addr_i), .sc_pred_i(sc_pred_i),
  .sc_cond_i(sc_cond_i), .sc_we_o(sc_we_o), .sc_status_valid_o(sc_status_valid_o),
  .sc_status_o(sc_status_o), .resv_valid_i(resv_valid)
);

// File: tb/llsc_resv_unit_test.sv
`timescale 1ns/1ps
module llsc_resv_unit_test;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 64;
  localparam logic [DATA_W-1:0] MSB1 = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MSB0 = {1'b0, {(DATA_W-1){1'b1}}};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic              ll_valid_i = 1'b0;
  logic [ADDR_W-1:0] ll_addr_i = '0;
  logic              snoop_valid_i = 1'b0;
  logic [ADDR_W-1:0] snoop_addr_i = '0;
  logic              sc_valid_i = 1'b0;
  logic [ADDR_W-1:0] sc_addr_i = '0;
  logic [1:0]        sc_pred_i = '0;
  logic [DATA_W-1:0] sc_cond_i = '0;
  logic              sc_we_o;
  logic              sc_status_valid_o;
  logic [DATA_W-1:0] sc_status_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  llsc_resv_unit uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs of that cycle's SC are visible on return
  task automatic cyc(input bit ll, input logic [31:0] lla,
                     input bit sn, input logic [31:0] sna,
                     input bit sc, input logic [31:0] sca,
                     input logic [1:0] pr, input logic [63:0] cd, input bit fl);
    @(negedge clk_i);
    ll_valid_i = ll; ll_addr_i = lla;
    snoop_valid_i = sn; snoop_addr_i = sna;
    sc_valid_i = sc; sc_addr_i = sca; sc_pred_i = pr; sc_cond_i = cd;
    flush_i = fl;
    @(negedge clk_i);
    ll_valid_i = 0; snoop_valid_i = 0; sc_valid_i = 0; flush_i = 0;
  endtask

  task automatic do_ll(input logic [31:0] a);
    cyc(1, a, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_snoop(input logic [31:0] a);
    cyc(0, 0, 1, a, 0, 0, 0, 0, 0);
  endtask

  task automatic chk_sc(input string req, input bit exp);
    check(sc_status_valid_o == 1'b1, req, "status valid", sc_status_valid_o, 1);
    check(sc_we_o == exp, req, "write enable", sc_we_o, exp);
    check(sc_status_o == DATA_W'(exp), req, "status", sc_status_o, exp);
  endtask

  task automatic do_sc(input logic [31:0] a, input logic [1:0] pr,
                       input logic [63:0] cd, input bit exp, input string req);
    cyc(0, 0, 0, 0, 1, a, pr, cd, 0);
    chk_sc(req, exp);
  endtask

  task automatic t_reset_r1();
    check(sc_we_o == 0, "R1", "we after reset", sc_we_o, 0);
    check(sc_status_valid_o == 0, "R1", "status valid after reset", sc_status_valid_o, 0);
    do_sc(32'h40, 2'd0, 0, 0, "R1");
  endtask

  task automatic t_basic_r2();
    do_ll(32'h100);
    do_sc(32'h100, 2'd0, 0, 1, "R2");
    do_ll(32'h180);
    do_ll(32'h1c0);
    do_sc(32'h180, 2'd0, 0, 1, "R2");
    do_sc(32'h1c0, 2'd0, 0, 1, "R2");
  endtask

  task automatic t_word_r3();
    do_ll(32'h300);
    do_sc(32'h307, 2'd0, 0, 1, "R3");
    do_ll(32'h300);
    do_snoop(32'h308);
    do_sc(32'h300, 2'd0, 0, 1, "R3");
    do_ll(32'h300);
    do_sc(32'h308, 2'd0, 0, 0, "R3");
    do_sc(32'h300, 2'd0, 0, 1, "R3");
  endtask

  task automatic t_snoop_r4();
    do_ll(32'h400);
    do_snoop(32'h404);
    do_sc(32'h400, 2'd0, 0, 0, "R4");
    do_ll(32'h400);
    do_ll(32'h500);
    do_snoop(32'h500);
    do_sc(32'h400, 2'd0, 0, 1, "R4");
    do_sc(32'h500, 2'd0, 0, 0, "R4");
  endtask

  task automatic t_consume_r5();
    do_ll(32'h600);
    do_sc(32'h600, 2'd0, 64'd5, 0, "R5");
    do_sc(32'h600, 2'd0, 0, 0, "R5");
    do_ll(32'h600);
    do_sc(32'h600, 2'd0, 0, 1, "R5");
    do_sc(32'h600, 2'd0, 0, 0, "R5");
  endtask

  task automatic t_pred_r6();
    do_ll(32'h700); do_sc(32'h700, 2'd1, 64'd1, 1, "R6");
    do_ll(32'h700); do_sc(32'h700, 2'd1, 64'd2, 0, "R6");
    do_ll(32'h700); do_sc(32'h700, 2'd2, MSB1, 1, "R6");
    do_ll(32'h700); do_sc(32'h700, 2'd2, MSB0, 0, "R6");
    do_ll(32'h700); do_sc(32'h700, 2'd3, 0, 0, "R6");
    do_ll(32'h700); do_sc(32'h700, 2'd0, 64'd1, 0, "R6");
  endtask

  task automatic t_status_r7();
    do_ll(32'h800);
    do_sc(32'h800, 2'd0, 0, 1, "R7");
    @(negedge clk_i);
    check(sc_status_valid_o == 0, "R7", "pulse length", sc_status_valid_o, 0);
    check(sc_we_o == 0, "R7", "we pulse length", sc_we_o, 0);
    do_ll(32'h800);
    check(sc_status_valid_o == 0, "R7", "no status without sc", sc_status_valid_o, 0);
  endtask

  task automatic t_flush_r8();
    do_ll(32'h900);
    do_ll(32'ha00);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    do_sc(32'h900, 2'd0, 0, 0, "R8");
    do_sc(32'ha00, 2'd0, 0, 0, "R8");
  endtask

  task automatic t_replace_r9();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    do_ll(32'h1000); do_ll(32'h1000);
    do_ll(32'h1100); do_ll(32'h1200); do_ll(32'h1300);
    do_sc(32'h1000, 2'd0, 0, 1, "R9");
    do_sc(32'h1100, 2'd0, 0, 1, "R9");
    do_sc(32'h1200, 2'd0, 0, 1, "R9");
    do_sc(32'h1300, 2'd0, 0, 1, "R9");
    do_ll(32'h2000); do_ll(32'h2100); do_ll(32'h2200); do_ll(32'h2300);
    do_ll(32'h2400);
    do_sc(32'h2000, 2'd0, 0, 0, "R9");
    do_sc(32'h2100, 2'd0, 0, 1, "R9");
    do_sc(32'h2400, 2'd0, 0, 1, "R9");
    do_sc(32'h2200, 2'd0, 0, 1, "R9");
    do_sc(32'h2300, 2'd0, 0, 1, "R9");
  endtask

  task automatic t_conflict_r10();
    do_ll(32'hb00);
    cyc(0, 0, 1, 32'hb04, 1, 32'hb00, 2'd0, 0, 0);
    chk_sc("R10", 0);
    cyc(1, 32'hc00, 1, 32'hc00, 0, 0, 0, 0, 0);
    do_sc(32'hc00, 2'd0, 0, 0, "R10");
    cyc(1, 32'hd00, 0, 0, 1, 32'hd00, 2'd0, 0, 0);
    chk_sc("R10", 0);
    do_sc(32'hd00, 2'd0, 0, 0, "R10");
  endtask

  task automatic t_flush_same_r11();
    do_ll(32'he00);
    cyc(0, 0, 0, 0, 1, 32'he00, 2'd0, 0, 1);
    chk_sc("R11", 0);
    cyc(1, 32'hf00, 0, 0, 0, 0, 0, 0, 1);
    do_sc(32'hf00, 2'd0, 0, 0, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_r1();
    t_basic_r2();
    t_word_r3();
    t_snoop_r4();
    t_consume_r5();
    t_pred_r6();
    t_status_r7();
    t_flush_r8();
    t_replace_r9();
    t_conflict_r10();
    t_flush_same_r11();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule